// File: doc/BRIEF.md
# Two-Level Nesting Interrupt Controller

This block gathers seventeen interrupt request lines in front of a processor core and raises a single request toward it. Each line has its own pending flag, enable bit and class bit. The class bit puts the line in either the urgent class or the normal class. The lowest-numbered lines are external pins, and each of them passes through an edge detector that can be set per pin to catch rising or falling transitions. The other lines are on-chip sources that set their flag on every cycle their input is high.

The request carries a fixed handler address for its class and the number of the line that caused it. The core accepts a request with a one-cycle acknowledge strobe and ends a handler with a one-cycle return strobe. The controller keeps a two-entry record of the handlers in progress. An urgent request can therefore interrupt a normal handler, and returns unwind in the reverse order. Software configures the block through a small write port with a select code.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After a synchronous reset, all enables, pending flags and the global enable are 0. Every class bit is 1 (urgent), every external edge select is 1 (rising), `irq_req` is 0 and `act_lvl` is 2'b00.
- R2: External lines 0..N_EXT-1 set their pending flag on a 0-to-1 input change when their edge-select bit is 1, and on a 1-to-0 change when it is 0. The other transition does not set the flag. Internal lines set their flag in every cycle their input is 1.
- R3: A pending flag stays set until a write with `cfg_sel`=3 carries a 1 in its bit position. If a trigger arrives in the same cycle as that clear, the flag stays set.
- R4: `irq_req` rises on the second clock edge after a trigger, counting the edge that sets the flag, provided the line's enable bit (`cfg_sel`=0) is 1 and no handler blocks it.
- R5: While the global enable (`cfg_sel`=4, bit 0) is 0, `irq_req` is 0 from the next edge on.
- R6: Class bits are written with `cfg_sel`=1 (1 = urgent). An urgent request reports `irq_vec`=0x000008 and a normal request reports 0x000018. When both classes have an eligible request, the urgent one is reported.
- R7: `irq_cause` is the lowest-numbered eligible line in the reported class.
- R8: An acknowledge while `irq_req` is 1 sets the active bit of the reported class, and `irq_req` is 0 in the following cycle.
- R9: While only a normal handler is active, an eligible urgent request raises `irq_req`.
- R10: A normal request is never raised while any handler is active. An urgent request is never raised while an urgent handler is active.
- R11: A return strobe clears the urgent active bit if it is set, and otherwise clears the normal active bit. A return in the same cycle as a taken acknowledge is ignored.
- R12: Edge selects are written with `cfg_sel`=2. `act_lvl` bit 1 shows an urgent handler in progress and bit 0 shows a normal one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | N_SRC | Raw request lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | 0 enable, 1 class, 2 edge select, 3 pending clear, 4 global enable |
| cfg_wdata | input | N_SRC | Configuration write data |
| irq_req | output | 1 | Registered request to the core |
| irq_vec | output | 24 | Handler address of the reported class |
| irq_cause | output | 5 | Number of the reported line |
| irq_ack | input | 1 | Acknowledge strobe |
| irq_ret | input | 1 | Return-from-handler strobe |
| act_lvl | output | 2 | Active handler record {urgent, normal} |

## Verification
A corrupted active-level record appears at the ports within one cycle. Either a request that should be blocked appears on `irq_req`, or a pre-empting urgent request stays silent. `act_lvl` shows any wrong push or pop on the edge that follows the strobe. A lost or wrongly kept pending flag appears two edges after the trigger or clear, as a missing, extra or misnumbered request. The bench therefore runs a nested normal/urgent sequence, simultaneous strobes and same-cycle clear-versus-trigger, and compares every port after each edge.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  typedef enum logic [2:0] {
    CFG_ENABLE = 3'd0,
    CFG_CLASS  = 3'd1,
    CFG_EDGE   = 3'd2,
    CFG_CLEAR  = 3'd3,
    CFG_GLOBAL = 3'd4
  } cfg_sel_e;
endpackage

// File: rtl/irq_trigger.sv
module irq_trigger #(
  parameter int N_SRC = 17,
  parameter int N_EXT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_in,
  input  logic [N_EXT-1:0] rise_sel,
  output logic [N_SRC-1:0] trig
);
  genvar i;
  generate
    for (i = 0; i < N_SRC; i++) begin : g_src
      if (i < N_EXT) begin : g_ext
        logic last_q;
        always_ff @(posedge clk) begin
          if (rst) last_q <= 1'b0;
          else     last_q <= src_in[i];
        end
        assign trig[i] = rise_sel[i] ? (src_in[i] & ~last_q) : (~src_in[i] & last_q);
      end else begin : g_int
        assign trig[i] = src_in[i];
      end
    end
  endgenerate
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N  = 17,
  parameter int CW = 5
) (
  input  logic [N-1:0]  cand,
  output logic          any,
  output logic [CW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        any = 1'b1;
        idx = CW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack (
  input  logic clk,
  input  logic rst,
  input  logic push,
  input  logic push_hi,
  input  logic pop,
  output logic hi_act,
  output logic lo_act
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_act <= 1'b0;
      lo_act <= 1'b0;
    end else if (push) begin
      if (push_hi) hi_act <= 1'b1;
      else         lo_act <= 1'b1;
    end else if (pop) begin
      if (hi_act)      hi_act <= 1'b0;
      else if (lo_act) lo_act <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl #(
  parameter int               N_SRC  = 17,
  parameter int               N_EXT  = 3,
  parameter int               VEC_W  = 24,
  parameter logic [VEC_W-1:0] VEC_HI = 24'h000008,
  parameter logic [VEC_W-1:0] VEC_LO = 24'h000018,
  localparam int              CW     = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_in,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [N_SRC-1:0] cfg_wdata,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic [CW-1:0]    irq_cause,
  input  logic             irq_ack,
  input  logic             irq_ret,
  output logic [1:0]       act_lvl
);
  import irq_nest_pkg::*;

  logic [N_SRC-1:0] en_q, cls_q, pend_q, trig, clr;
  logic [N_EXT-1:0] rise_q;
  logic             gie_q;
  logic [N_SRC-1:0] elig_hi, elig_lo;
  logic             any_hi, any_lo, take_hi, take_lo;
  logic [CW-1:0]    idx_hi, idx_lo;
  logic             cls_hi_q, hi_act, lo_act, ack_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      cls_q  <= '1;
      rise_q <= '1;
      gie_q  <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_sel_e'(cfg_sel))
        CFG_ENABLE: en_q   <= cfg_wdata;
        CFG_CLASS:  cls_q  <= cfg_wdata;
        CFG_EDGE:   rise_q <= cfg_wdata[N_EXT-1:0];
        CFG_GLOBAL: gie_q  <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  irq_trigger #(.N_SRC(N_SRC), .N_EXT(N_EXT)) u_trig (
    .clk(clk), .rst(rst), .src_in(src_in), .rise_sel(rise_q), .trig(trig)
  );

  assign clr = (cfg_we && cfg_sel == CFG_CLEAR) ? cfg_wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr) | trig;
  end

  assign elig_hi = pend_q & en_q & {N_SRC{gie_q}} & cls_q;
  assign elig_lo = pend_q & en_q & {N_SRC{gie_q}} & ~cls_q;

  irq_pick #(.N(N_SRC), .CW(CW)) u_pick_hi (.cand(elig_hi), .any(any_hi), .idx(idx_hi));
  irq_pick #(.N(N_SRC), .CW(CW)) u_pick_lo (.cand(elig_lo), .any(any_lo), .idx(idx_lo));

  assign take_hi = any_hi & ~hi_act;
  assign take_lo = any_lo & ~hi_act & ~lo_act;
  assign ack_ok  = irq_ack & irq_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req   <= 1'b0;
      irq_vec   <= VEC_HI;
      irq_cause <= '0;
      cls_hi_q  <= 1'b1;
    end else begin
      irq_req <= (take_hi | take_lo) & ~ack_ok;
      if (take_hi) begin
        irq_vec   <= VEC_HI;
        irq_cause <= idx_hi;
        cls_hi_q  <= 1'b1;
      end else if (take_lo) begin
        irq_vec   <= VEC_LO;
        irq_cause <= idx_lo;
        cls_hi_q  <= 1'b0;
      end
    end
  end

  irq_level_stack u_stack (
    .clk(clk), .rst(rst), .push(ack_ok), .push_hi(cls_hi_q),
    .pop(irq_ret & ~ack_ok), .hi_act(hi_act), .lo_act(lo_act)
  );

  assign act_lvl = {hi_act, lo_act};
endmodule

// File: rtl/irq_nest_ctrl_chk.sv
module irq_nest_ctrl_chk #(
  parameter int               VEC_W  = 24,
  parameter logic [VEC_W-1:0] VEC_LO = 24'h000018
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec,
  input logic             irq_ack,
  input logic             irq_ret,
  input logic [1:0]       act_lvl,
  input logic             gie
);
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    !gie |=> !irq_req); // R5
  AST_NO_LO_OVER_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (act_lvl != 2'b00) |-> !(irq_req && irq_vec == VEC_LO)); // R10
  AST_PUSH_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    ($rose(act_lvl[1]) || $rose(act_lvl[0])) |-> $past(irq_ack && irq_req)); // R8
  AST_REQ_DROPS: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_req) |=> !irq_req); // R8
  AST_POP_HI_FIRST: assert property (@(posedge clk) disable iff (rst)
    (irq_ret && !(irq_ack && irq_req) && act_lvl[1])
      |=> (!act_lvl[1] && act_lvl[0] == $past(act_lvl[0]))); // R11
endmodule

bind irq_nest_ctrl irq_nest_ctrl_chk #(.VEC_W(VEC_W), .VEC_LO(VEC_LO)) u_chk (
  .clk(clk), .rst(rst), .irq_req(irq_req), .irq_vec(irq_vec),
  .irq_ack(irq_ack), .irq_ret(irq_ret), .act_lvl(act_lvl), .gie(gie_q)
);

// File: tb/irq_nest_ctrl_tb.sv
`timescale 1ns/1ps
module irq_nest_ctrl_tb;
  localparam int N = 17;
  localparam logic [23:0] VH = 24'h000008;
  localparam logic [23:0] VL = 24'h000018;

  typedef struct {
    logic       req;
    logic [23:0] vec;
    logic [4:0] cause;
    logic [1:0] act;
    string      tag;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] src_in = '0, cfg_wdata = '0;
  logic cfg_we = 1'b0, irq_ack = 1'b0, irq_ret = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic irq_req;
  logic [23:0] irq_vec;
  logic [4:0] irq_cause;
  logic [1:0] act_lvl;

  int checks = 0, errors = 0;
  bit done = 0;
  exp_t sb[$];
  event chk_ev;

  always #4 clk = ~clk;

  irq_nest_ctrl u_dut (
    .clk(clk), .rst(rst), .src_in(src_in), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_cause(irq_cause), .irq_ack(irq_ack), .irq_ret(irq_ret), .act_lvl(act_lvl)
  );

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic expect_out(logic rq, logic [23:0] v, logic [4:0] c, logic [1:0] a, string tag);
    exp_t e;
    e.req = rq; e.vec = v; e.cause = c; e.act = a; e.tag = tag;
    sb.push_back(e);
    -> chk_ev;
    #0;
  endtask

  task automatic wr(logic [2:0] sel, logic [N-1:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic strobe(logic a, logic r);
    irq_ack = a; irq_ret = r;
    step();
    irq_ack = 1'b0; irq_ret = 1'b0;
  endtask

  initial begin
    forever begin
      @(chk_ev);
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (irq_req !== e.req || act_lvl !== e.act ||
            (e.req && (irq_vec !== e.vec || irq_cause !== e.cause))) begin
          errors++;
          $display("FAIL %s: got req=%b vec=%h cause=%0d act=%b, expected req=%b vec=%h cause=%0d act=%b",
                   e.tag, irq_req, irq_vec, irq_cause, act_lvl, e.req, e.vec, e.cause, e.act);
        end
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step();
    expect_out(0, VH, 0, 2'b00, "R1 reset state");
    // internal line 5 pulses while disabled
    src_in[5] = 1'b1; step(); src_in[5] = 1'b0; step();
    expect_out(0, VH, 0, 2'b00, "R1 enables clear after reset");
    wr(3'd0, '1); step();
    expect_out(0, VH, 0, 2'b00, "R5 global enable off");
    wr(3'd4, 17'd1); step();
    expect_out(1, VH, 5, 2'b00, "R1 default urgent class, R3 flag kept");
    strobe(1, 0);
    expect_out(0, VH, 0, 2'b10, "R8 ack pushes urgent");
    step();
    expect_out(0, VH, 0, 2'b10, "R10 same level blocked");
    wr(3'd3, 17'h00020);
    strobe(0, 1);
    expect_out(0, VH, 0, 2'b00, "R11 return pops urgent");
    // lines 7 and 9 become normal class
    wr(3'd1, 17'h1FFFF & ~17'h00280);
    src_in[7] = 1'b1; src_in[9] = 1'b1; step();
    src_in[7] = 1'b0; src_in[9] = 1'b0; step();
    expect_out(1, VL, 7, 2'b00, "R6 normal vector, R7 lowest line");
    strobe(1, 0);
    expect_out(0, VH, 0, 2'b01, "R8 ack pushes normal");
    step();
    expect_out(0, VH, 0, 2'b01, "R10 normal blocked by normal");
    src_in[0] = 1'b1; step(2);
    expect_out(1, VH, 0, 2'b01, "R9 urgent pre-empts, R2 rising edge");
    strobe(1, 1);
    expect_out(0, VH, 0, 2'b11, "R11 ack wins over return, R12 nested");
    step();
    expect_out(0, VH, 0, 2'b11, "R10 nothing over urgent");
    wr(3'd3, 17'h00001);
    strobe(0, 1);
    expect_out(0, VH, 0, 2'b01, "R11 urgent popped first");
    step();
    expect_out(0, VH, 0, 2'b01, "R10 pending normal still blocked");
    wr(3'd3, 17'h00280);
    strobe(0, 1);
    expect_out(0, VH, 0, 2'b00, "R11 normal popped");
    step();
    expect_out(0, VH, 0, 2'b00, "R3 cleared flags stay clear");
    // line 1 to falling edge
    wr(3'd2, 17'h1FFFD);
    src_in[1] = 1'b1; step(2);
    expect_out(0, VH, 0, 2'b00, "R2 rise ignored on falling select");
    src_in[1] = 1'b0; step(2);
    expect_out(1, VH, 1, 2'b00, "R2 falling edge taken, R4 latency");
    wr(3'd4, 17'd0); step();
    expect_out(0, VH, 0, 2'b00, "R5 global disable drops request");
    wr(3'd3, 17'h00002); wr(3'd4, 17'd1); step();
    expect_out(0, VH, 0, 2'b00, "R3 clear removes request");
    src_in[3] = 1'b1; src_in[9] = 1'b1; src_in[12] = 1'b1; step();
    src_in[3] = 1'b0; src_in[9] = 1'b0; src_in[12] = 1'b0; step();
    expect_out(1, VH, 3, 2'b00, "R6 urgent over normal, R7 line 3");
    wr(3'd3, 17'h00008); step();
    expect_out(1, VH, 12, 2'b00, "R7 next urgent line 12");
    wr(3'd3, 17'h01000); step();
    expect_out(1, VL, 9, 2'b00, "R6 normal after urgent cleared");
    wr(3'd3, 17'h00200); step();
    expect_out(0, VH, 0, 2'b00, "R3 all cleared");
    src_in[4] = 1'b1; step(2);
    expect_out(1, VH, 4, 2'b00, "R4 level line 4 requests");
    wr(3'd3, 17'h00010); step();
    expect_out(1, VH, 4, 2'b00, "R3 trigger beats clear");
    src_in[4] = 1'b0; wr(3'd3, 17'h00010); step();
    expect_out(0, VH, 0, 2'b00, "R3 clear after trigger ends");
    wr(3'd0, 17'h1FFBF);
    src_in[6] = 1'b1; step(); src_in[6] = 1'b0; step();
    expect_out(0, VH, 0, 2'b00, "R4 disabled line masked");
    wr(3'd0, '1); step();
    expect_out(1, VH, 6, 2'b00, "R4 enable releases pending line");
    step();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule